// File: doc/BRIEF.md
# Word Store Decode and Issue Unit

This block takes a fetched instruction, either a 16-bit halfword or a 32-bit wide word, and works out whether it is a word store with an immediate offset. Four layouts are recognised. Two are narrow: one with a general base register and a 5-bit scaled offset, and one with the stack pointer as base and an 8-bit scaled offset. Two are wide: one with a 12-bit unscaled offset, and one with an 8-bit offset plus pre/post indexing, add/subtract and base update controls. Every accepted instruction gets a class: a legal store, an undefined encoding, an unpredictable encoding, an encoding that belongs to a different instruction (aliases), or not a store at all.

The decode result is registered. When the result is a legal store, a second stage samples the base and source register values that the surrounding pipeline presents in the cycle when the decode result is valid. From these it forms the effective address, and it raises a word write request that holds until the memory side returns ready. The register-update strobe for the base fires in the same cycle as that handshake. The unit takes one instruction at a time. It lowers its input ready while a decode result or a store is in flight.

Top module: `stw_store_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, dec_valid, mem_req and wb_en are 0 and in_ready is 1.
- R2: With in_wide=0 and in_word[15:11]=01100, the class is store (code 1). The source is {0,in_word[2:0]}, the base is {0,in_word[5:3]} and the offset is in_word[10:6]*4. pre=1, add=1, wb=0.
- R3: With in_wide=0 and in_word[15:11]=10010, the class is store. The source is {0,in_word[10:8]}, the base is 13 (stack pointer) and the offset is in_word[7:0]*4. pre=1, add=1, wb=0.
- R4: With in_wide=1 and in_word[31:20]=0xF8C, the base is in_word[19:16], the source is in_word[15:12] and the offset is in_word[11:0]. pre=1, add=1, wb=0. A base of 15 gives undefined (code 2). Otherwise a source of 15 gives unpredictable (code 3).
- R5: With in_wide=1, in_word[31:20]=0xF84 and in_word[11]=1, the fields are P=in_word[10], U=in_word[9], W=in_word[8], offset in_word[7:0], base in_word[19:16] and source in_word[15:12]. A legal store reports pre=P, add=U, wb=W.
- R6: In the R5 layout, the class is alias (code 4) when PUW=110, or when base=13 with PUW=101 and offset 4. Alias takes priority over R7.
- R7: In the R5 layout, and when R6 does not apply, the class is undefined when the base is 15 or when P=W=0. Otherwise it is unpredictable when the source is 15, or when W=1 with base equal to source.
- R8: Any other input is not-a-store (code 0). For every class other than store, the source, base, offset, pre, add and wb outputs are 0.
- R9: An instruction accepted (in_valid and in_ready high) at a clock edge shows on dec_valid and the dec_* outputs after that edge, for exactly one cycle.
- R10: The cycle after a store's dec_valid, mem_req rises. mem_addr is the offset address (base ± offset, modulo 2^32) when pre=1, and the unmodified base when pre=0. mem_data is the source value.
- R11: mem_req, mem_addr and mem_data hold until mem_ready is sampled high, and mem_req drops after that edge.
- R12: wb_en is high only in the handshake cycle (mem_req and mem_ready) of a store with wb=1. wb_reg is the base index and wb_data is the offset address.
- R13: in_ready is low while dec_valid or mem_req is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_wide | input | 1 | 1 = 32-bit instruction, 0 = 16-bit in bits 15:0 |
| in_word | input | 32 | Instruction bits |
| in_ready | output | 1 | Unit can accept an instruction |
| dec_valid | output | 1 | Decode result valid this cycle |
| dec_class | output | 3 | 0 none, 1 store, 2 undefined, 3 unpredictable, 4 alias |
| dec_src | output | 4 | Source register index |
| dec_base | output | 4 | Base register index |
| dec_offset | output | 32 | Zero-extended byte offset |
| dec_pre | output | 1 | Address uses offset (pre-index) |
| dec_add | output | 1 | Offset is added (else subtracted) |
| dec_wb | output | 1 | Base is updated |
| base_val | input | 32 | Base register value, valid with dec_valid |
| src_val | input | 32 | Source register value, valid with dec_valid |
| mem_req | output | 1 | Word write request |
| mem_addr | output | 32 | Write address |
| mem_data | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts request |
| wb_en | output | 1 | Base register update strobe |
| wb_reg | output | 4 | Register to update |
| wb_data | output | 32 | Value for the base register |

## Verification
The memory handshake and the base-update strobe share one cycle: the edge that retires the request is also the only cycle that carries wb_en. The bench holds mem_ready low for random stretches, so wb_en must stay silent while the request waits. It then raises mem_ready on post-indexed, pre-indexed and subtracting stores. In that cycle the reference model checks that the write address and the update value differ exactly as the indexing mode requires. Base values near zero with subtracted offsets make the wraparound visible in both results at once.

// File: rtl/stw_pkg.sv
package stw_pkg;
  localparam int XW   = 32;
  localparam int RW   = 4;
  localparam logic [RW-1:0] REG_SP = 4'd13;
  localparam logic [RW-1:0] REG_PC = 4'd15;

  typedef enum logic [2:0] {
    SC_NONE   = 3'd0,
    SC_STORE  = 3'd1,
    SC_UNDEF  = 3'd2,
    SC_UNPRED = 3'd3,
    SC_ALIAS  = 3'd4
  } st_class_e;

  typedef struct packed {
    st_class_e       cls;
    logic [RW-1:0]   src;
    logic [RW-1:0]   base;
    logic [XW-1:0]   off;
    logic            pre;
    logic            add;
    logic            wb;
  } st_dec_t;

  function automatic logic [XW-1:0] stw_offs_addr(input logic [XW-1:0] b,
                                                  input logic [XW-1:0] o,
                                                  input logic          add);
    return add ? (b + o) : (b - o);
  endfunction

  function automatic logic [XW-1:0] stw_eff_addr(input logic [XW-1:0] b,
                                                 input logic [XW-1:0] o,
                                                 input logic          add,
                                                 input logic          pre);
    return pre ? stw_offs_addr(b, o, add) : b;
  endfunction
endpackage

// File: rtl/stw_decode.sv
module stw_decode
  import stw_pkg::*;
(
  input  logic          wide,
  input  logic [XW-1:0] word,
  output st_dec_t       dec
);
  logic [15:0]   hw;
  logic [RW-1:0] rn, rt;
  logic [2:0]    puw;
  logic [7:0]    imm8;
  logic          n_base, n_sp, w_imm12, w_imm8;
  logic          alias_hit, undef_hit, unpred_hit;

  assign hw      = word[15:0];
  assign rn      = word[19:16];
  assign rt      = word[15:12];
  assign puw     = word[10:8];
  assign imm8    = word[7:0];
  assign n_base  = !wide && (hw[15:11] == 5'b01100);
  assign n_sp    = !wide && (hw[15:11] == 5'b10010);
  assign w_imm12 = wide && (word[31:20] == 12'hF8C);
  assign w_imm8  = wide && (word[31:20] == 12'hF84) && word[11];

  // Priority inside the 8-bit wide layout: alias, undefined, unpredictable.
  assign alias_hit  = (puw == 3'b110) || (rn == REG_SP && puw == 3'b101 && imm8 == 8'd4);
  assign undef_hit  = (rn == REG_PC) || (!puw[2] && !puw[0]);
  assign unpred_hit = (rt == REG_PC) || (puw[0] && rn == rt);

  always_comb begin
    dec = '0;
    dec.cls = SC_NONE;
    if (n_base) begin
      dec.cls  = SC_STORE;
      dec.src  = {1'b0, hw[2:0]};
      dec.base = {1'b0, hw[5:3]};
      dec.off  = {{(XW-7){1'b0}}, hw[10:6], 2'b00};
      dec.pre  = 1'b1;
      dec.add  = 1'b1;
    end else if (n_sp) begin
      dec.cls  = SC_STORE;
      dec.src  = {1'b0, hw[10:8]};
      dec.base = REG_SP;
      dec.off  = {{(XW-10){1'b0}}, hw[7:0], 2'b00};
      dec.pre  = 1'b1;
      dec.add  = 1'b1;
    end else if (w_imm12) begin
      if (rn == REG_PC)      dec.cls = SC_UNDEF;
      else if (rt == REG_PC) dec.cls = SC_UNPRED;
      else begin
        dec.cls  = SC_STORE;
        dec.src  = rt;
        dec.base = rn;
        dec.off  = {{(XW-12){1'b0}}, word[11:0]};
        dec.pre  = 1'b1;
        dec.add  = 1'b1;
      end
    end else if (w_imm8) begin
      if (alias_hit)       dec.cls = SC_ALIAS;
      else if (undef_hit)  dec.cls = SC_UNDEF;
      else if (unpred_hit) dec.cls = SC_UNPRED;
      else begin
        dec.cls  = SC_STORE;
        dec.src  = rt;
        dec.base = rn;
        dec.off  = {{(XW-8){1'b0}}, imm8};
        dec.pre  = puw[2];
        dec.add  = puw[1];
        dec.wb   = puw[0];
      end
    end
  end
endmodule

// File: rtl/stw_agu.sv
module stw_agu
  import stw_pkg::*;
(
  input  logic [XW-1:0] base_v,
  input  logic [XW-1:0] off,
  input  logic          add,
  input  logic          pre,
  output logic [XW-1:0] addr,
  output logic [XW-1:0] upd
);
  assign upd  = stw_offs_addr(base_v, off, add);
  assign addr = stw_eff_addr(base_v, off, add, pre);
endmodule

// File: rtl/stw_issue.sv
module stw_issue
  import stw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  st_dec_t       dec,
  input  logic [XW-1:0] base_v,
  input  logic [XW-1:0] src_v,
  input  logic          mem_ready,
  output logic          mem_req,
  output logic [XW-1:0] mem_addr,
  output logic [XW-1:0] mem_data,
  output logic          wb_en,
  output logic [RW-1:0] wb_reg,
  output logic [XW-1:0] wb_data
);
  logic [XW-1:0] agu_addr, agu_upd;
  logic          wb_q;
  logic          handshake;

  stw_agu u_agu (
    .base_v (base_v),
    .off    (dec.off),
    .add    (dec.add),
    .pre    (dec.pre),
    .addr   (agu_addr),
    .upd    (agu_upd)
  );

  assign handshake = mem_req && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      wb_q     <= 1'b0;
      wb_reg   <= '0;
      wb_data  <= '0;
    end else if (launch) begin
      mem_req  <= 1'b1;
      mem_addr <= agu_addr;
      mem_data <= src_v;
      wb_q     <= dec.wb;
      wb_reg   <= dec.base;
      wb_data  <= agu_upd;
    end else if (handshake) begin
      mem_req  <= 1'b0;
    end
  end

  assign wb_en = handshake && wb_q;

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

  assert_wb_in_handshake_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (mem_req && mem_ready));
endmodule

// File: rtl/stw_store_unit.sv
module stw_store_unit
  import stw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_wide,
  input  logic [31:0]   in_word,
  output logic          in_ready,
  output logic          dec_valid,
  output logic [2:0]    dec_class,
  output logic [3:0]    dec_src,
  output logic [3:0]    dec_base,
  output logic [31:0]   dec_offset,
  output logic          dec_pre,
  output logic          dec_add,
  output logic          dec_wb,
  input  logic [31:0]   base_val,
  input  logic [31:0]   src_val,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_data,
  input  logic          mem_ready,
  output logic          wb_en,
  output logic [3:0]    wb_reg,
  output logic [31:0]   wb_data
);
  st_dec_t dec_c, dec_q;
  logic    accept, launch;

  stw_decode u_dec (
    .wide (in_wide),
    .word (in_word),
    .dec  (dec_c)
  );

  assign in_ready = !dec_valid && !mem_req;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_q     <= '0;
    end else begin
      dec_valid <= accept;
      if (accept) dec_q <= dec_c;
    end
  end

  assign launch     = dec_valid && (dec_q.cls == SC_STORE);
  assign dec_class  = dec_q.cls;
  assign dec_src    = dec_q.src;
  assign dec_base   = dec_q.base;
  assign dec_offset = dec_q.off;
  assign dec_pre    = dec_q.pre;
  assign dec_add    = dec_q.add;
  assign dec_wb     = dec_q.wb;

  stw_issue u_iss (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .dec       (dec_q),
    .base_v    (base_val),
    .src_v     (src_val),
    .mem_ready (mem_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .wb_en     (wb_en),
    .wb_reg    (wb_reg),
    .wb_data   (wb_data)
  );

  assert_accept_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> dec_valid);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  assert_busy_blocks_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || dec_valid) |-> !in_ready);

  assert_nonstore_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_class != 3'd1) |->
      (dec_offset == 32'd0 && dec_src == 4'd0 && dec_base == 4'd0 && !dec_pre && !dec_add && !dec_wb));

  assert_store_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_class == 3'd1) |=> mem_req);
endmodule

// File: tb/tb_stw_store_unit.sv
module tb_stw_store_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0, in_wide = 0, mem_ready = 0;
  logic [31:0] in_word = 0, base_val = 0, src_val = 0;
  logic        in_ready, dec_valid, dec_pre, dec_add, dec_wb, mem_req, wb_en;
  logic [2:0]  dec_class;
  logic [3:0]  dec_src, dec_base, wb_reg;
  logic [31:0] dec_offset, mem_addr, mem_data, wb_data;

  always #5 clk = ~clk;

  stw_store_unit dut (.*);

  int vectors = 0, errors = 0;

  // reference state
  logic        m_dv, m_req, m_wbf;
  int          m_cls, m_src, m_base;
  logic [31:0] m_off, m_addr, m_data, m_wdata;
  logic        m_pre, m_add, m_wb;
  int          m_wreg;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Independent decode: classify by layout, then by fields.
  task automatic ref_dec(input logic w, input logic [31:0] x,
                         output int cls, output int s, output int b, output logic [31:0] o,
                         output logic p, output logic a, output logic wbk);
    int rn, rt, pw;
    cls = 0; s = 0; b = 0; o = 0; p = 0; a = 0; wbk = 0;
    rn = x[19:16]; rt = x[15:12]; pw = x[10:8];
    if (!w && x[15:11] == 5'b01100) begin       // R2
      cls = 1; s = x[2:0]; b = x[5:3]; o = x[10:6] * 4; p = 1; a = 1;
    end else if (!w && x[15:11] == 5'b10010) begin // R3
      cls = 1; s = x[10:8]; b = 13; o = x[7:0] * 4; p = 1; a = 1;
    end else if (w && x[31:20] == 12'hF8C) begin // R4
      if (rn == 15) cls = 2;
      else if (rt == 15) cls = 3;
      else begin cls = 1; s = rt; b = rn; o = x[11:0]; p = 1; a = 1; end
    end else if (w && x[31:20] == 12'hF84 && x[11]) begin // R5 R6 R7
      if (pw == 6 || (rn == 13 && pw == 5 && x[7:0] == 4)) cls = 4;
      else if (rn == 15 || (pw % 2 == 0 && pw < 4)) cls = 2;
      else if (rt == 15 || (pw % 2 == 1 && rn == rt)) cls = 3;
      else begin
        cls = 1; s = rt; b = rn; o = x[7:0];
        p = pw >= 4; a = (pw / 2) % 2 == 1; wbk = pw % 2 == 1;
      end
    end
  endtask

  logic [32:0] dlist [0:21];
  initial begin
    dlist[0]  = {1'b0, 32'h0000_655A}; dlist[1]  = {1'b0, 32'h0000_97FF};
    dlist[2]  = {1'b1, 32'hF8C1_2FFF}; dlist[3]  = {1'b1, 32'hF8CF_1000};
    dlist[4]  = {1'b1, 32'hF8C1_F004}; dlist[5]  = {1'b1, 32'hF841_2C10};
    dlist[6]  = {1'b1, 32'hF841_2B04}; dlist[7]  = {1'b1, 32'hF841_2E04};
    dlist[8]  = {1'b1, 32'hF84D_2D04}; dlist[9]  = {1'b1, 32'hF84D_2D08};
    dlist[10] = {1'b1, 32'hF84F_2C04}; dlist[11] = {1'b1, 32'hF841_2804};
    dlist[12] = {1'b1, 32'hF841_2A04}; dlist[13] = {1'b1, 32'hF841_FC04};
    dlist[14] = {1'b1, 32'hF841_1D04}; dlist[15] = {1'b1, 32'hF841_1C04};
    dlist[16] = {1'b1, 32'hF841_2F08}; dlist[17] = {1'b1, 32'hF841_2904};
    dlist[18] = {1'b1, 32'hF841_2404}; dlist[19] = {1'b0, 32'h0000_4000};
    dlist[20] = {1'b0, 32'hF8C1_2FFF}; dlist[21] = {1'b1, 32'hF84F_2E04};
  end

  task automatic gen(input int k, output logic w, output logic [31:0] x);
    int r;
    if (k < 22) begin w = dlist[k][32]; x = dlist[k][31:0]; return; end
    x = $urandom; r = $urandom % 6;
    case (r)
      0: begin w = 0; x[15:11] = 5'b01100; end
      1: begin w = 0; x[15:11] = 5'b10010; end
      2: begin w = 1; x[31:20] = 12'hF8C; end
      3: begin w = 1; x[31:20] = 12'hF84; x[11] = 1; end
      4: w = 0;
      default: w = 1;
    endcase
  endtask

  logic done = 0;

  initial begin
    int item = 0;
    logic acc = 0;
    logic nw;
    logic [31:0] nx;
    m_dv = 0; m_req = 0; m_wbf = 0; m_cls = 0; m_src = 0; m_base = 0;
    m_off = 0; m_pre = 0; m_add = 0; m_wb = 0; m_addr = 0; m_data = 0; m_wreg = 0; m_wdata = 0;
    gen(0, nw, nx);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (cyc == 3) rst_n = 1;
      if (acc) begin item++; gen(item, nw, nx); end
      in_wide  = nw; in_word = nx;
      in_valid = ($urandom % 10) < 7;
      mem_ready = ($urandom % 3) != 0;
      base_val = (($urandom % 4) == 0) ? ($urandom % 16) : $urandom;
      src_val  = $urandom;
      #1;
      if (!rst_n || cyc == 3) begin // R1
        chk("R1 dec_valid", dec_valid, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 wb_en", wb_en, 0);
        chk("R1 in_ready", in_ready, 1);
      end
      chk("R13 in_ready", in_ready, !m_dv && !m_req);
      chk("R9 dec_valid", dec_valid, m_dv);
      if (m_dv) begin
        chk("R6 R7 R8 dec_class", dec_class, m_cls);
        chk("R2 R3 R4 R5 dec_src", dec_src, m_src);
        chk("R2 R3 R4 R5 dec_base", dec_base, m_base);
        chk("R2 R3 R4 R5 dec_offset", dec_offset, m_off);
        chk("R5 R8 dec_pre", dec_pre, m_pre);
        chk("R5 R8 dec_add", dec_add, m_add);
        chk("R5 R8 dec_wb", dec_wb, m_wb);
      end
      chk("R11 mem_req", mem_req, m_req);
      if (m_req) begin
        chk("R10 mem_addr", mem_addr, m_addr);
        chk("R10 mem_data", mem_data, m_data);
      end
      chk("R12 wb_en", wb_en, m_req && mem_ready && m_wbf);
      if (m_req && mem_ready && m_wbf) begin
        chk("R12 wb_reg", wb_reg, m_wreg);
        chk("R12 wb_data", wb_data, m_wdata);
      end
      @(posedge clk);
      acc = 0;
      if (rst_n) begin
        acc = in_valid && !m_dv && !m_req;
        if (m_req && mem_ready) m_req = 0;
        if (m_dv && m_cls == 1) begin
          logic [31:0] moved;
          moved = m_add ? base_val + m_off : base_val - m_off;
          m_req = 1; m_data = src_val; m_wbf = m_wb; m_wreg = m_base;
          m_wdata = moved; m_addr = m_pre ? moved : base_val;
        end
        m_dv = acc;
        if (acc) ref_dec(in_wide, in_word, m_cls, m_src, m_base, m_off, m_pre, m_add, m_wb);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule